// File: doc/BRIEF.md
# Fine-Grained Hardware Thread Issue Scheduler

This block decides, on every clock cycle, which of several hardware thread contexts may place an instruction into a shared single-issue pipeline. It rotates among the threads that are eligible, so consecutive cycles normally go to different threads and a thread switch costs no cycle. The pick is combinational from the cycle's registered state and the per-thread valid inputs.

A thread leaves the rotation while it waits on something slow. A load that misses the first-level cache removes it until the load-completion strobe for that thread arrives. A branch removes it until the resolve strobe arrives, because no prediction is made. A load that hits the first-level cache blocks the thread only for a short fixed window. This keeps a result that is not yet available from being consumed even when too few threads are eligible for the rotation alone to cover the hit latency.

The issue output has no back-pressure. The pipeline takes the selected thread's instruction in the cycle it is selected, so `issue_vld` is a plain strobe and not a valid/ready pair. All event and completion inputs are per-thread pulse vectors, and each is sampled on the rising clock edge.

Top module: `thread_issue_sched`

## Requirements
- R1: `issue_sel` has at most one bit set, and `issue_vld` is high exactly when a bit of `issue_sel` is set.
- R2: A thread whose `thr_valid` bit is low is never selected.
- R3: The search starts at the thread after the last one issued, wrapping from the last thread to thread 0. The first eligible thread found is selected in the same cycle. A thread is eligible when its valid bit is high, it has no pending miss or branch, and its hit window has expired.
- R4: When no thread is eligible, `issue_vld` is low, `issue_sel` is zero, and the rotation position keeps its value.
- R5: A `ld_miss` pulse for a thread in cycle k makes that thread ineligible from cycle k+1. A `ld_done` pulse for it in cycle j clears the miss wait, so the thread can be selected again in cycle j+1.
- R6: A `br_issue` pulse for a thread in cycle k makes that thread ineligible from cycle k+1. A `br_done` pulse in cycle j clears the branch wait from cycle j+1.
- R7: A `ld_hit` pulse for a thread in cycle k makes it ineligible in cycles k+1 through k+L1_LAT-1, and it may be selected again from cycle k+L1_LAT. With the default L1_LAT of 3, the window covers two cycles.
- R8: When a stall event and the matching completion arrive for the same thread in the same cycle, the stall event wins and the thread stays ineligible. The miss and branch waits are tracked independently.
- R9: A synchronous active-high `rst` clears all waits and hit windows and points the rotation at thread 0. In the first cycle after reset, with all threads valid, thread 0 is selected.
- R10: When `issue_vld` is high, `issue_id` is the binary index of the set bit of `issue_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| thr_valid | input | N | Per-thread flag: an instruction is ready to issue |
| ld_hit | input | N | Per-thread pulse: a load hit the first-level cache |
| ld_miss | input | N | Per-thread pulse: a load missed the first-level cache |
| ld_done | input | N | Per-thread pulse: the outstanding missed load has returned |
| br_issue | input | N | Per-thread pulse: a branch was issued |
| br_done | input | N | Per-thread pulse: the branch condition is resolved |
| issue_sel | output | N | One-hot select of the issuing thread |
| issue_id | output | $clog2(N) | Binary index of the issuing thread |
| issue_vld | output | 1 | An instruction issues this cycle |

## Verification
The bench builds the block with four threads and an L1_LAT of 3. At these values the pointer wrap from the last thread back to thread 0 and the two-cycle hit window are reached within a handful of cycles. With only one thread valid, the full hit window shows up directly as idle cycles at the output. With all four valid, the rotation hides the window completely. Long random runs mix misses, branches and same-cycle stall and completion pairs across all four contexts.

// File: rtl/thread_sel_pkg.sv
package thread_sel_pkg;

  // Readiness view of one hardware thread, as seen by the picker.
  typedef struct packed {
    logic miss_wait;  // waiting for a missed load to return
    logic br_wait;    // waiting for a branch to resolve
    logic hold_busy;  // inside the short window after a cache hit
  } thr_status_t;

  function automatic logic thr_blocked(thr_status_t s);
    return s.miss_wait | s.br_wait | s.hold_busy;
  endfunction

endpackage

// File: rtl/thr_ready_track.sv
module thr_ready_track
  import thread_sel_pkg::*;
#(
  parameter int L1_LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_hit,
  input  logic        ld_miss,
  input  logic        ld_done,
  input  logic        br_issue,
  input  logic        br_done,
  output thr_status_t status
);

  localparam int HOLD = (L1_LAT > 1) ? L1_LAT - 1 : 0;
  localparam int CW   = (HOLD < 1) ? 1 : $clog2(HOLD + 1);

  logic          miss_q;
  logic          br_q;
  logic [CW-1:0] hold_cnt;

  // Stall events take priority over a completion in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      miss_q <= 1'b0;
    end else if (ld_miss) begin
      miss_q <= 1'b1;
    end else if (ld_done) begin
      miss_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_q <= 1'b0;
    end else if (br_issue) begin
      br_q <= 1'b1;
    end else if (br_done) begin
      br_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
    end else if (ld_hit) begin
      hold_cnt <= CW'(HOLD);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_comb begin
    status.miss_wait = miss_q;
    status.br_wait   = br_q;
    status.hold_busy = (hold_cnt != '0);
  end

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]                   req,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] start,
  output logic [N-1:0]                   gnt,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] gnt_idx,
  output logic                           any
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // Scan forward from the start position and take the first request.
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(start) + off) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import thread_sel_pkg::*;
#(
  parameter int N      = 4,
  parameter int L1_LAT = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N-1:0]                    thr_valid,
  input  logic [N-1:0]                    ld_hit,
  input  logic [N-1:0]                    ld_miss,
  input  logic [N-1:0]                    ld_done,
  input  logic [N-1:0]                    br_issue,
  input  logic [N-1:0]                    br_done,
  output logic [N-1:0]                    issue_sel,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] issue_id,
  output logic                            issue_vld
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  thr_status_t       status [N];
  logic [N-1:0]      eligible;
  logic [IW-1:0]     rr_ptr;
  logic [N-1:0]      pick_sel;
  logic [IW-1:0]     pick_id;
  logic              pick_any;

  for (genvar t = 0; t < N; t++) begin : g_thr
    thr_ready_track #(.L1_LAT(L1_LAT)) u_track (
      .clk      (clk),
      .rst      (rst),
      .ld_hit   (ld_hit[t]),
      .ld_miss  (ld_miss[t]),
      .ld_done  (ld_done[t]),
      .br_issue (br_issue[t]),
      .br_done  (br_done[t]),
      .status   (status[t])
    );
    assign eligible[t] = thr_valid[t] & ~thr_blocked(status[t]);
  end

  rr_pick #(.N(N)) u_pick (
    .req     (eligible),
    .start   (rr_ptr),
    .gnt     (pick_sel),
    .gnt_idx (pick_id),
    .any     (pick_any)
  );

  // Rotation position: one past the last issued thread, held when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (pick_any) begin
      if (pick_id == IW'(N - 1)) begin
        rr_ptr <= '0;
      end else begin
        rr_ptr <= pick_id + 1'b1;
      end
    end
  end

  assign issue_sel = pick_sel;
  assign issue_id  = pick_id;
  assign issue_vld = pick_any;

endmodule

// File: rtl/thread_issue_sched_chk.sv
module thread_issue_sched_chk #(
  parameter int N      = 4,
  parameter int L1_LAT = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic [N-1:0]                    thr_valid,
  input logic [N-1:0]                    ld_hit,
  input logic [N-1:0]                    ld_miss,
  input logic [N-1:0]                    br_issue,
  input logic [N-1:0]                    issue_sel,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0] issue_id,
  input logic                            issue_vld,
  input logic [((N > 1) ? $clog2(N) : 1)-1:0] rr_ptr
);

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_sel));

  assert_vld_match_R1: assert property (@(posedge clk) disable iff (rst)
    issue_vld == (issue_sel != '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> $stable(rr_ptr));

  assert_reset_start_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && thr_valid[0]) |-> issue_sel[0]);

  assert_id_match_R10: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> issue_sel[issue_id]);

  for (genvar t = 0; t < N; t++) begin : g_thr_chk
    assert_sel_valid_R2: assert property (@(posedge clk) disable iff (rst)
      issue_sel[t] |-> thr_valid[t]);

    // Also covers R8: a completion in the same cycle does not lift the stall.
    assert_miss_block_R5: assert property (@(posedge clk) disable iff (rst)
      ld_miss[t] |=> !issue_sel[t]);

    assert_br_block_R6: assert property (@(posedge clk) disable iff (rst)
      br_issue[t] |=> !issue_sel[t]);

    if (L1_LAT > 1) begin : g_hit
      assert_hit_block_R7: assert property (@(posedge clk) disable iff (rst)
        ld_hit[t] |=> !issue_sel[t]);
    end
  end

endmodule

bind thread_issue_sched thread_issue_sched_chk #(.N(N), .L1_LAT(L1_LAT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .thr_valid (thr_valid),
  .ld_hit    (ld_hit),
  .ld_miss   (ld_miss),
  .br_issue  (br_issue),
  .issue_sel (issue_sel),
  .issue_id  (issue_id),
  .issue_vld (issue_vld),
  .rr_ptr    (rr_ptr)
);

// File: tb/thread_issue_sched_bench.sv
module thread_issue_sched_bench;

  localparam int NT  = 4;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NT-1:0] thr_valid = '0;
  logic [NT-1:0] ld_hit    = '0;
  logic [NT-1:0] ld_miss   = '0;
  logic [NT-1:0] ld_done   = '0;
  logic [NT-1:0] br_issue  = '0;
  logic [NT-1:0] br_done   = '0;
  logic [NT-1:0] issue_sel;
  logic [1:0]    issue_id;
  logic          issue_vld;

  int errs   = 0;
  int checks = 0;

  // Behavioural reference state.
  int m_miss [NT];
  int m_br   [NT];
  int m_hold [NT];
  int m_ptr;

  always #5 clk = ~clk;

  thread_issue_sched #(.N(NT), .L1_LAT(LAT)) u_thread_issue_sched (
    .clk       (clk),
    .rst       (rst),
    .thr_valid (thr_valid),
    .ld_hit    (ld_hit),
    .ld_miss   (ld_miss),
    .ld_done   (ld_done),
    .br_issue  (br_issue),
    .br_done   (br_done),
    .issue_sel (issue_sel),
    .issue_id  (issue_id),
    .issue_vld (issue_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < NT; t++) begin
      m_miss[t] = 0;
      m_br[t]   = 0;
      m_hold[t] = 0;
    end
    m_ptr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    thr_valid = '0; ld_hit = '0; ld_miss = '0;
    ld_done = '0; br_issue = '0; br_done = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // One cycle: drive at the falling edge, compare after settling, advance the model.
  task automatic step(input string tag, input logic [NT-1:0] v, input logic [NT-1:0] hit,
                      input logic [NT-1:0] miss, input logic [NT-1:0] done,
                      input logic [NT-1:0] bi, input logic [NT-1:0] bd);
    logic [NT-1:0] e_sel;
    int            e_id;
    logic          e_vld;
    @(negedge clk);
    thr_valid = v; ld_hit = hit; ld_miss = miss;
    ld_done = done; br_issue = bi; br_done = bd;
    #1;
    e_sel = '0; e_id = 0; e_vld = 1'b0;
    for (int off = 0; off < NT; off++) begin
      int t;
      t = (m_ptr + off) % NT;
      if (!e_vld && v[t] && m_miss[t] == 0 && m_br[t] == 0 && m_hold[t] == 0) begin
        e_vld = 1'b1; e_sel[t] = 1'b1; e_id = t;
      end
    end
    chk("R1 onehot", 32'($countones(issue_sel) <= 1), 32'd1);
    chk({tag, " select"}, 32'(issue_sel), 32'(e_sel));
    chk("R4 issue_vld", 32'(issue_vld), 32'(e_vld));
    if (e_vld) chk("R10 issue_id", 32'(issue_id), 32'(e_id));
    for (int t = 0; t < NT; t++) begin
      if (miss[t]) m_miss[t] = 1; else if (done[t]) m_miss[t] = 0;
      if (bi[t]) m_br[t] = 1; else if (bd[t]) m_br[t] = 0;
      if (hit[t]) m_hold[t] = LAT - 1; else if (m_hold[t] > 0) m_hold[t]--;
    end
    if (e_vld) m_ptr = (e_id + 1) % NT;
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R9: first pick after reset is thread 0; R3: rotation order and wrap.
    step("R9", 4'hF, 0, 0, 0, 0, 0);
    chk("R9 first pick", 32'(issue_sel), 32'h1);
    step("R3", 4'hF, 0, 0, 0, 0, 0);
    chk("R3 second pick", 32'(issue_sel), 32'h2);
    step("R3", 4'hF, 0, 0, 0, 0, 0);
    step("R3", 4'hF, 0, 0, 0, 0, 0);
    chk("R3 last thread", 32'(issue_sel), 32'h8);
    step("R3", 4'hF, 0, 0, 0, 0, 0);
    chk("R3 wrap", 32'(issue_sel), 32'h1);

    // R2: only valid threads are picked.
    step("R2", 4'b0100, 0, 0, 0, 0, 0);
    chk("R2 only valid", 32'(issue_sel), 32'h4);

    // R7: lone thread with a cache hit idles for two cycles.
    step("R7", 4'b0001, 4'b0001, 0, 0, 0, 0);
    step("R7", 4'b0001, 0, 0, 0, 0, 0);
    chk("R7 hold 1", 32'(issue_vld), 32'd0);
    step("R7", 4'b0001, 0, 0, 0, 0, 0);
    chk("R7 hold 2", 32'(issue_vld), 32'd0);
    step("R7", 4'b0001, 0, 0, 0, 0, 0);
    chk("R7 release", 32'(issue_sel), 32'h1);

    // R5: miss on thread 1 removes it until the done strobe.
    step("R5", 4'hF, 0, 4'b0010, 0, 0, 0);
    repeat (6) step("R5", 4'hF, 0, 0, 0, 0, 0);
    step("R5", 4'b0010, 0, 0, 4'b0010, 0, 0);
    chk("R5 still out on done cycle", 32'(issue_vld), 32'd0);
    step("R5", 4'b0010, 0, 0, 0, 0, 0);
    chk("R5 back next cycle", 32'(issue_sel), 32'h2);

    // R6: branch on thread 2.
    step("R6", 4'hF, 0, 0, 0, 4'b0100, 0);
    repeat (5) step("R6", 4'hF, 0, 0, 0, 0, 0);
    step("R6", 4'b0100, 0, 0, 0, 0, 4'b0100);
    step("R6", 4'b0100, 0, 0, 0, 0, 0);
    chk("R6 back after resolve", 32'(issue_sel), 32'h4);

    // R8: stall and completion together; stall wins.
    step("R8", 4'hF, 0, 4'b1000, 4'b1000, 4'b0001, 4'b0001);
    step("R8", 4'b1001, 0, 0, 0, 0, 0);
    chk("R8 stall wins", 32'(issue_vld), 32'd0);
    step("R8", 4'b1001, 0, 0, 4'b1000, 0, 4'b0001);
    step("R8", 4'b1001, 0, 0, 0, 0, 0);

    // R4: idle cycles keep the rotation position.
    step("R4", 4'hF, 0, 0, 0, 0, 0);
    repeat (3) step("R4", 4'h0, 0, 0, 0, 0, 0);
    step("R4", 4'hF, 0, 0, 0, 0, 0);

    // Random traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      logic [NT-1:0] v, h, ms, dn, bi, bd;
      v  = 4'($urandom) | 4'($urandom);
      h  = 4'($urandom) & 4'($urandom);
      ms = 4'($urandom) & 4'($urandom) & 4'($urandom);
      dn = 4'($urandom) & 4'($urandom);
      bi = 4'($urandom) & 4'($urandom) & 4'($urandom);
      bd = 4'($urandom) & 4'($urandom);
      step("R3 random", v, h, ms, dn, bi, bd);
    end

    // R9 again mid-run.
    do_reset();
    step("R9", 4'hF, 0, 0, 0, 0, 0);
    chk("R9 after second reset", 32'(issue_sel), 32'h1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule